// File: doc/BRIEF.md
# Cascadable Synchronous Binary Up-Counter

This block is a chain of identical binary up-counter stages that together form one wide counter. Each stage has a synchronous clear, a synchronous parallel load and two count enables. One enable is shared by every stage. The other is chained: it comes from the terminal-count flag of the stage below. A stage's terminal-count flag rises only when its count is all ones and its chained enable is high, so a carry moves up the chain in the same clock cycle, without ripple through the stage registers.

Every state change happens on the rising clock edge, and the controls have a fixed priority. Clear comes first, then load, then increment, then hold. The stage width and the number of stages are parameters, with defaults of four bits and two stages. With those defaults the chain is an 8-bit counter, and the bench uses it to exercise the carry across the boundary from 15 to 16.

Top module: `cascade_counter`

## Requirements
- R1: When clrN is low at a rising clock edge, every count bit is zero after that edge, whatever loadN, enGlobal, enChain and dataIn are.
- R2: When clrN is high and loadN is low at a rising edge, countOut takes the value of dataIn on that edge, whatever the two enables are.
- R3: When clrN and loadN are both high and both enGlobal and enChain are high at a rising edge, countOut increases by one modulo 2^(STAGES*STAGE_W), so all ones wraps to zero.
- R4: When clrN and loadN are high and either enable is low at a rising edge, countOut keeps its value.
- R5: Each stage's terminal count is high exactly when its chained enable is high and its own count is all ones. The flag is combinational and follows the enable within the same cycle, with no clock edge in between.
- R6: Stage k's terminal count drives the chained enable of stage k+1, and enGlobal drives every stage, so the chain counts as one wide counter that carries from the low stage into the next, for example from 15 to 16.
- R7: termCount is high exactly when enChain is high and all bits of countOut are ones.
- R8: Bit i of dataIn loads into bit i of countOut. Stage k holds bits [k*STAGE_W +: STAGE_W], with stage 0 least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clrN | input | 1 | Active-low synchronous clear, highest priority |
| loadN | input | 1 | Active-low synchronous parallel load |
| enGlobal | input | 1 | Count enable shared by all stages |
| enChain | input | 1 | Chained count enable into stage 0 |
| dataIn | input | STAGES*STAGE_W | Parallel load value |
| countOut | output | STAGES*STAGE_W | Current count |
| termCount | output | 1 | Terminal count of the last stage, for chaining further |

## Verification
The hardest condition to reach from the ports is the full-carry case. Here every stage is all ones at the same time as both enables are high, so the count wraps to zero and termCount is high in the cycle before. The bench gets there quickly by loading values just below each boundary (0x0E, 0xFE) and counting through them, and it does not step through the whole range. It also holds the count at all ones with the global enable low, then toggles enChain in the middle of a cycle, to show that terminal count follows the chained enable without a clock edge.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic inc;
  } stageStrobe_t;
endpackage

// File: rtl/counter_ctrl.sv
module counter_ctrl
  import cascade_counter_pkg::*;
(
  input  logic         clrN,
  input  logic         loadN,
  input  logic         enP,
  input  logic         enT,
  output stageStrobe_t strobe
);
  // Fixed priority: clear, then load, then increment, otherwise hold.
  always_comb begin
    strobe.clear = !clrN;
    strobe.load  = clrN && !loadN;
    strobe.inc   = clrN && loadN && enP && enT;
  end
endmodule

// File: rtl/counter_datapath.sv
module counter_datapath
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  stageStrobe_t     strobe,
  input  logic             enT,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (strobe.clear)     q <= '0;
    else if (strobe.load) q <= loadVal;
    else if (strobe.inc)  q <= q + ONE;
  end

  // Lookahead carry: gated only by the chained enable.
  assign tc = enT && (&q);
endmodule

// File: rtl/counter_stage.sv
module counter_stage
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic             enP,
  input  logic             enT,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  stageStrobe_t strobe;

  counter_ctrl ctrlInst (
    .clrN  (clrN),
    .loadN (loadN),
    .enP   (enP),
    .enT   (enT),
    .strobe(strobe)
  );

  counter_datapath #(.WIDTH(WIDTH)) dpInst (
    .clk    (clk),
    .strobe (strobe),
    .enT    (enT),
    .loadVal(loadVal),
    .q      (q),
    .tc     (tc)
  );
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2
) (
  input  logic                        clk,
  input  logic                        clrN,
  input  logic                        loadN,
  input  logic                        enGlobal,
  input  logic                        enChain,
  input  logic [STAGES*STAGE_W-1:0]   dataIn,
  output logic [STAGES*STAGE_W-1:0]   countOut,
  output logic                        termCount
);
  localparam int TOTAL_W = STAGES * STAGE_W;

  logic [STAGES:0] chainEn;
  assign chainEn[0] = enChain;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    counter_stage #(.WIDTH(STAGE_W)) stageInst (
      .clk    (clk),
      .clrN   (clrN),
      .loadN  (loadN),
      .enP    (enGlobal),
      .enT    (chainEn[k]),
      .loadVal(dataIn[k*STAGE_W +: STAGE_W]),
      .q      (countOut[k*STAGE_W +: STAGE_W]),
      .tc     (chainEn[k+1])
    );
  end

  assign termCount = chainEn[STAGES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int TOTAL_W = 8
) (
  input logic               clk,
  input logic               clrN,
  input logic               loadN,
  input logic               enGlobal,
  input logic               enChain,
  input logic [TOTAL_W-1:0] dataIn,
  input logic [TOTAL_W-1:0] countOut,
  input logic               termCount
);
  // The count is undefined until the first clear; checks start after it.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clrN) primed <= 1'b1;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!primed)
    !clrN |=> countOut == '0);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!primed)
    (clrN && !loadN) |=> countOut == $past(dataIn));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!primed)
    (clrN && loadN && enGlobal && enChain) |=>
      countOut == TOTAL_W'($past(countOut) + TOTAL_W'(1)));

  // R4
  hold_value_chk: assert property (@(posedge clk) disable iff (!primed)
    (clrN && loadN && !(enGlobal && enChain)) |=> $stable(countOut));

  // R7
  term_count_chk: assert property (@(posedge clk) disable iff (!primed)
    termCount == (enChain && (&countOut)));
endmodule

bind cascade_counter cascade_counter_chk #(.TOTAL_W(TOTAL_W)) chkInst (
  .clk      (clk),
  .clrN     (clrN),
  .loadN    (loadN),
  .enGlobal (enGlobal),
  .enChain  (enChain),
  .dataIn   (dataIn),
  .countOut (countOut),
  .termCount(termCount)
);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clrN = 1'b0, loadN = 1'b1, enGlobal = 1'b0, enChain = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] countOut;
  logic         termCount;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cascade_counter dut (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enGlobal(enGlobal),
    .enChain(enChain), .dataIn(dataIn), .countOut(countOut),
    .termCount(termCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, check terminal count, clock, compare count.
  task automatic step(input bit c, input bit l, input bit eg, input bit ec,
                      input int d);
    string req;
    clrN = c; loadN = l; enGlobal = eg; enChain = ec; dataIn = W'(d);
    #1;
    check((model == 255) ? "R7 R5" : "R7", int'(termCount),
          int'(ec && model == 255));
    if (!c)             begin model = 0;                 req = "R1"; end
    else if (!l)        begin model = d & 255;           req = "R2 R8"; end
    else if (eg && ec)  begin
      req = (model % 16 == 15) ? "R3 R6" : "R3";
      model = (model + 1) % 256;
    end
    else                req = "R4";
    @(posedge clk);
    @(negedge clk);
    check(req, int'(countOut), model);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Reset state: clear with everything else active (R1).
    step(0, 0, 1, 1, 8'hA5);
    check("R1", int'(countOut), 0);
    // Load regardless of enables (R2, R8).
    step(1, 0, 0, 0, 8'h3C);
    step(1, 0, 1, 1, 8'h0E);
    // Count across 15 -> 16 (R3, R6).
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 0);
    // Hold: each enable low alone (R4).
    step(1, 1, 0, 1, 0);
    step(1, 1, 1, 0, 0);
    step(1, 1, 0, 0, 0);
    // Low stage at 15 with chain enable low: no carry (R4, R5).
    step(1, 0, 1, 1, 8'h2F);
    step(1, 1, 1, 0, 0);
    check("R6", int'(countOut), 8'h2F);
    // Wrap from all ones (R3, R7).
    step(1, 0, 0, 0, 8'hFE);
    step(1, 1, 1, 1, 0);
    step(1, 1, 1, 1, 0);
    check("R3", int'(countOut), 0);
    // Terminal count follows enChain mid-cycle (R5, R7).
    step(1, 0, 0, 1, 8'hFF);
    enChain = 1'b0; #2;
    check("R5", int'(termCount), 0);
    enChain = 1'b1; #2;
    check("R5", int'(termCount), 1);
    // Clear beats load (R1).
    step(0, 0, 0, 0, 8'h77);
    // Bit mapping (R8).
    step(1, 0, 0, 0, 8'h81);
    step(1, 0, 1, 1, 8'h5A);
    // Longer run through several stage carries (R3, R6).
    for (int i = 0; i < 60; i++) step(1, 1, 1, (i % 7) != 3, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule